// File: doc/BRIEF.md
# Command-Bus DMA Request Decoder

This block sits at the end of a narrow command bus and converts what it receives into three kinds of action: a single register write, a refresh request to the memory controller, or a DMA transfer that it counts out beat by beat. It shows through `ready` when it can take a new command. A register write and a DMA request each span two consecutive bus cycles. The first carries the command code and an address. The second carries the idle code with either the write data or a packed transfer descriptor.

For a DMA request the block unpacks the descriptor, waits a programmable number of cycles, and then marks the transfer's beats with `xfer_start` (first beat of a burst) and `xfer_last` (final beat of a burst). A sequential transfer is one burst of length-plus-one beats. A subblock read is split into six back-to-back bursts of 2, 2, 4, 4, 4 and 4 beats. The target address, device, direction and a non-sequential hint are held on outputs for the data path while the transfer runs. A refresh command produces a one-cycle `ctl_load` pulse.

The controller is a seven-state machine. In IDLE, `ready` is high and the command code is decoded. WRITE goes to WR_DATA, REFRESH goes to REFRESH, DMA goes to DMA_DESC, and IDLE stays in IDLE. WR_DATA always goes to WR_ISSUE, and WR_ISSUE always returns to IDLE. REFRESH always returns to IDLE. DMA_DESC goes straight to DMA_BEAT when the computed wait is one cycle, and to DMA_WAIT otherwise. DMA_WAIT counts down to DMA_BEAT. DMA_BEAT returns to IDLE on the final beat of the final burst.

Top module: `cmd_dma_decoder`

## Requirements
- R1: After reset, `ready` is 1, and `wr_en`, `ctl_load`, `xfer_start` and `xfer_last` are 0.
- R2: A write command (code 1) accepted while `ready` is high is followed by a data word in the next cycle. In the cycle after that data word, `wr_en` is 1 for exactly one cycle, `wr_addr` shows the first word and `wr_data` shows the second. `ready` returns to 1 in the following cycle.
- R3: A refresh command (code 2) accepted while `ready` is high makes `ctl_load` 1 for exactly one cycle, in the next cycle, with `ready` low there. `ready` is high again in the cycle after that.
- R4: A DMA command (code 3) is followed by a descriptor word whose bits are read as follows. Bits 7:0 are the length, bit 8 is read (1) or write (0), bits 12:9 are the signed delay, bits 16:13 are the device, bit 17 is the non-sequential hint, bit 18 is down, bit 19 is masked and bit 20 is subblock. Bits 31:21 are ignored.
- R5: A sequential transfer with length field L yields L+1 consecutive beats. `xfer_start` is 1 on the first beat only, and `xfer_last` is 1 on the final beat only.
- R6: A length field of 0 yields a single beat on which `xfer_start` and `xfer_last` are both 1.
- R7: Let the wait be w = max(1, 3 + delay). The first `xfer_start` appears in the w-th cycle after the clock edge that captures the descriptor, and no beat is marked before it.
- R8: A subblock read ignores the length field and produces six back-to-back bursts of 2, 2, 4, 4, 4 and 4 beats, each with its own start and last marker. The subblock bit has no effect on a write, and the masked bit has no effect on a read.
- R9: `xfer_nonseq` equals hint OR down OR (masked AND write) OR (subblock AND read).
- R10: A command code presented while `ready` is low has no effect, and the idle code has no effect while `ready` is high.
- R11: `ready` is low from the cycle after a command is accepted until the final beat of the final burst, and is high in the cycle after it.
- R12: From the first beat to the end of the transfer, `xfer_addr`, `xfer_dev` and `xfer_read` show the first word's address and the descriptor's device and read fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_code | input | 2 | Command code: 0 idle, 1 write, 2 refresh, 3 DMA |
| cmd_data | input | 32 | Address, write data or descriptor word |
| ready | output | 1 | High when a command can be accepted |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 32 | Register write data |
| ctl_load | output | 1 | One-cycle refresh control-load pulse |
| xfer_start | output | 1 | First beat of a burst |
| xfer_last | output | 1 | Final beat of a burst |
| xfer_addr | output | 32 | Transfer start address |
| xfer_dev | output | 4 | Transfer device field |
| xfer_read | output | 1 | Transfer is a read |
| xfer_nonseq | output | 1 | Transfer is non-sequential |

## Verification
The hardest case to reach from the ports is a stream of refresh or write codes that arrive while a long transfer is still waiting or counting. The sequencer must ignore every one of them and still release `ready` exactly one cycle after the final marker. To get there, the table-driven loop drives a junk command code on every cycle of selected transfers, including one with the largest delay. It checks at each cycle that no strobe leaks out. The same table also reaches the delay clamp with the most negative delay, the maximum length of 256 beats, and the subblock and masked bits applied in the direction where they must be ignored.

// File: rtl/cmddec_pkg.sv
package cmddec_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_WRITE   = 2'd1,
        CMD_REFRESH = 2'd2,
        CMD_DMA     = 2'd3
    } cmd_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_DATA,
        ST_WR_ISSUE,
        ST_REFRESH,
        ST_DMA_DESC,
        ST_DMA_WAIT,
        ST_DMA_BEAT
    } state_e;

endpackage

// File: rtl/cmddec_desc_unpack.sv
module cmddec_desc_unpack #(
    parameter int DEV_W    = 4,
    parameter int DLY_W    = 4,
    parameter int LEN_W    = 8,
    parameter int WAIT_W   = 4,
    parameter int BASE_LAT = 3,
    localparam int DESC_W  = LEN_W + 1 + DLY_W + DEV_W + 4
) (
    input  logic [DESC_W-1:0] word,
    output logic [LEN_W-1:0]  len,
    output logic              is_read,
    output logic [DEV_W-1:0]  dev,
    output logic              nonseq,
    output logic              sub_burst,
    output logic [WAIT_W-1:0] wait_cycles
);
    localparam int READ_BIT = LEN_W;
    localparam int DLY_LSB  = LEN_W + 1;
    localparam int DEV_LSB  = DLY_LSB + DLY_W;
    localparam int HINT_BIT = DEV_LSB + DEV_W;
    localparam int DOWN_BIT = HINT_BIT + 1;
    localparam int MASK_BIT = DOWN_BIT + 1;
    localparam int SUB_BIT  = MASK_BIT + 1;

    logic [DLY_W-1:0] dly;
    logic             hint, down, masked, sub;
    int               sum;

    always_comb begin
        len     = word[LEN_W-1:0];
        is_read = word[READ_BIT];
        dly     = word[DLY_LSB +: DLY_W];
        dev     = word[DEV_LSB +: DEV_W];
        hint    = word[HINT_BIT];
        down    = word[DOWN_BIT];
        masked  = word[MASK_BIT];
        sub     = word[SUB_BIT];

        // masked only counts on writes, subblock only on reads
        sub_burst = sub & is_read;
        nonseq    = hint | down | (masked & ~is_read) | sub_burst;

        sum = BASE_LAT + int'($signed(dly));
        if (sum < 1) begin
            sum = 1;
        end
        wait_cycles = WAIT_W'(sum);
    end

endmodule

// File: rtl/cmddec_beat_seq.sv
module cmddec_beat_seq #(
    parameter int LEN_W     = 8,
    parameter int SHORT_LEN = 2,
    parameter int SHORT_CNT = 2,
    parameter int LONG_LEN  = 4,
    parameter int LONG_CNT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sub_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             advance,
    output logic             is_first,
    output logic             is_final,
    output logic             all_done
);
    localparam int NBURST = SHORT_CNT + LONG_CNT;
    localparam int IDX_W  = (NBURST > 1) ? $clog2(NBURST) : 1;

    logic [LEN_W-1:0] left_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nx;
    logic             sub_q;
    logic             first_q;

    function automatic logic [LEN_W-1:0] burst_top(input logic [IDX_W-1:0] i);
        if (i < IDX_W'(SHORT_CNT)) begin
            return LEN_W'(SHORT_LEN - 1);
        end
        return LEN_W'(LONG_LEN - 1);
    endfunction

    assign idx_nx = idx_q + IDX_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            idx_q   <= '0;
            sub_q   <= 1'b0;
            first_q <= 1'b0;
        end else if (load) begin
            sub_q   <= sub_in;
            idx_q   <= '0;
            first_q <= 1'b1;
            left_q  <= sub_in ? burst_top('0) : len_in;
        end else if (advance) begin
            if (left_q == '0) begin
                if (!all_done) begin
                    idx_q   <= idx_nx;
                    left_q  <= burst_top(idx_nx);
                    first_q <= 1'b1;
                end
            end else begin
                left_q  <= left_q - LEN_W'(1);
                first_q <= 1'b0;
            end
        end
    end

    always_comb begin
        is_first = first_q;
        is_final = (left_q == '0);
        all_done = is_final && (!sub_q || idx_q == IDX_W'(NBURST - 1));
    end

endmodule

// File: rtl/cmd_dma_decoder.sv
module cmd_dma_decoder
    import cmddec_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int DEV_W         = 4,
    parameter int DLY_W         = 4,
    parameter int LEN_W         = 8,
    parameter int BASE_LAT      = 3,
    parameter int SUB_SHORT_LEN = 2,
    parameter int SUB_SHORT_CNT = 2,
    parameter int SUB_LONG_LEN  = 4,
    parameter int SUB_LONG_CNT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_code,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              ready,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              ctl_load,
    output logic              xfer_start,
    output logic              xfer_last,
    output logic [DATA_W-1:0] xfer_addr,
    output logic [DEV_W-1:0]  xfer_dev,
    output logic              xfer_read,
    output logic              xfer_nonseq
);
    localparam int DESC_W = LEN_W + 1 + DLY_W + DEV_W + 4;
    localparam int WAIT_W = $clog2(BASE_LAT + (1 << (DLY_W - 1)) + 1);

    state_e            state_q, state_d;
    cmd_code_e         cmd;
    logic [DATA_W-1:0] addr_q, wdata_q;
    logic [DEV_W-1:0]  dev_q;
    logic              read_q, nonseq_q;
    logic [WAIT_W-1:0] wait_q;

    logic [LEN_W-1:0]  u_len;
    logic              u_read, u_nonseq, u_sub;
    logic [DEV_W-1:0]  u_dev;
    logic [WAIT_W-1:0] u_wait;

    logic              seq_load, seq_adv, seq_first, seq_final, seq_done;

    assign cmd = cmd_code_e'(cmd_code);

    cmddec_desc_unpack #(
        .DEV_W    (DEV_W),
        .DLY_W    (DLY_W),
        .LEN_W    (LEN_W),
        .WAIT_W   (WAIT_W),
        .BASE_LAT (BASE_LAT)
    ) unpack_i (
        .word        (cmd_data[DESC_W-1:0]),
        .len         (u_len),
        .is_read     (u_read),
        .dev         (u_dev),
        .nonseq      (u_nonseq),
        .sub_burst   (u_sub),
        .wait_cycles (u_wait)
    );

    cmddec_beat_seq #(
        .LEN_W     (LEN_W),
        .SHORT_LEN (SUB_SHORT_LEN),
        .SHORT_CNT (SUB_SHORT_CNT),
        .LONG_LEN  (SUB_LONG_LEN),
        .LONG_CNT  (SUB_LONG_CNT)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .sub_in   (u_sub),
        .len_in   (u_len),
        .advance  (seq_adv),
        .is_first (seq_first),
        .is_final (seq_final),
        .all_done (seq_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                case (cmd)
                    CMD_WRITE:   state_d = ST_WR_DATA;
                    CMD_REFRESH: state_d = ST_REFRESH;
                    CMD_DMA:     state_d = ST_DMA_DESC;
                    default:     state_d = ST_IDLE;
                endcase
            end
            ST_WR_DATA:  state_d = ST_WR_ISSUE;
            ST_WR_ISSUE: state_d = ST_IDLE;
            ST_REFRESH:  state_d = ST_IDLE;
            ST_DMA_DESC: state_d = (u_wait == WAIT_W'(1)) ? ST_DMA_BEAT : ST_DMA_WAIT;
            ST_DMA_WAIT: state_d = (wait_q == '0) ? ST_DMA_BEAT : ST_DMA_WAIT;
            ST_DMA_BEAT: state_d = seq_done ? ST_IDLE : ST_DMA_BEAT;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        ready      = (state_q == ST_IDLE);
        wr_en      = (state_q == ST_WR_ISSUE);
        ctl_load   = (state_q == ST_REFRESH);
        seq_load   = (state_q == ST_DMA_DESC);
        seq_adv    = (state_q == ST_DMA_BEAT);
        xfer_start = (state_q == ST_DMA_BEAT) && seq_first;
        xfer_last  = (state_q == ST_DMA_BEAT) && seq_final;
    end

    // captured command data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            dev_q    <= '0;
            read_q   <= 1'b0;
            nonseq_q <= 1'b0;
            wait_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && (cmd == CMD_WRITE || cmd == CMD_DMA)) begin
                addr_q <= cmd_data;
            end
            if (state_q == ST_WR_DATA) begin
                wdata_q <= cmd_data;
            end
            if (state_q == ST_DMA_DESC) begin
                dev_q    <= u_dev;
                read_q   <= u_read;
                nonseq_q <= u_nonseq;
                wait_q   <= (u_wait > WAIT_W'(1)) ? u_wait - WAIT_W'(2) : '0;
            end else if (state_q == ST_DMA_WAIT && wait_q != '0) begin
                wait_q <= wait_q - WAIT_W'(1);
            end
        end
    end

    assign wr_addr     = addr_q;
    assign wr_data     = wdata_q;
    assign xfer_addr   = addr_q;
    assign xfer_dev    = dev_q;
    assign xfer_read   = read_q;
    assign xfer_nonseq = nonseq_q;

endmodule

// File: rtl/cmd_dma_decoder_chk.sv
module cmd_dma_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_code,
    input logic       ready,
    input logic       wr_en,
    input logic       ctl_load,
    input logic       xfer_start,
    input logic       xfer_last
);
    // R11
    marker_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || xfer_last) |-> !ready);

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !xfer_last) |=> !xfer_start);

    // R11
    after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |=> (xfer_start || ready));

    // R3
    refresh_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_code == 2'd2) |=> (ctl_load && !ready));

    // R3
    ctl_load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_load |=> (!ctl_load && ready));

    // R2
    write_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cmd_code == 2'd1) |=> (!ready && !wr_en));

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!wr_en && ready));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || xfer_last) |-> (!ctl_load && !wr_en));

endmodule

bind cmd_dma_decoder cmd_dma_decoder_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_code   (cmd_code),
    .ready      (ready),
    .wr_en      (wr_en),
    .ctl_load   (ctl_load),
    .xfer_start (xfer_start),
    .xfer_last  (xfer_last)
);

// File: tb/cmd_dma_decoder_tb_top.sv
module cmd_dma_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_code = 2'd0;
    logic [31:0] cmd_data = '0;
    logic        ready, wr_en, ctl_load, xfer_start, xfer_last;
    logic        xfer_read, xfer_nonseq;
    logic [31:0] wr_addr, wr_data, xfer_addr;
    logic [3:0]  xfer_dev;

    int n_checks = 0;
    int n_fail   = 0;

    // descriptor {sub, masked, down, hint, dev[3:0], delay[3:0], read, len[7:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'h1, 4'h0, 1'b0, 8'd3},
        {1'b0, 1'b0, 1'b0, 1'b0, 4'h2, 4'hE, 1'b1, 8'd0},
        {1'b0, 1'b0, 1'b1, 1'b0, 4'h3, 4'h7, 1'b0, 8'd5},
        {1'b1, 1'b0, 1'b0, 1'b1, 4'h4, 4'h0, 1'b1, 8'd9},
        {1'b1, 1'b0, 1'b0, 1'b0, 4'h5, 4'h1, 1'b0, 8'd2},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h6, 4'h8, 1'b1, 8'd1},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'h7, 4'hF, 1'b0, 8'd7},
        {1'b0, 1'b0, 1'b0, 1'b1, 4'h8, 4'h2, 1'b1, 8'd2},
        {1'b0, 1'b0, 1'b0, 1'b0, 4'hF, 4'h0, 1'b1, 8'hFF}
    };

    cmd_dma_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_code    (cmd_code),
        .cmd_data    (cmd_data),
        .ready       (ready),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ctl_load    (ctl_load),
        .xfer_start  (xfer_start),
        .xfer_last   (xfer_last),
        .xfer_addr   (xfer_addr),
        .xfer_dev    (xfer_dev),
        .xfer_read   (xfer_read),
        .xfer_nonseq (xfer_nonseq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic run_dma(input logic [20:0] d, input logic [31:0] addr, input logic [1:0] junk);
        bit          sub, masked, down, hint, rd;
        logic [3:0]  dev;
        logic [7:0]  len;
        int          w, nb, blen, exp_ns;
        sub = d[20]; masked = d[19]; down = d[18]; hint = d[17];
        dev = d[16:13]; rd = d[8]; len = d[7:0];
        w = 3 + int'($signed(d[12:9]));
        if (w < 1) w = 1;
        exp_ns = int'(hint | down | (masked & !rd) | (sub & rd));
        nb = (sub && rd) ? 6 : 1;

        while (!ready) @(negedge clk);
        cmd_code = 2'd3;
        cmd_data = addr;
        @(negedge clk);
        check("R11", "ready after DMA accept", ready, 0);
        cmd_code = 2'd0;
        cmd_data = {11'h5A5, d};
        @(negedge clk);
        cmd_code = junk;
        cmd_data = 32'hFFFF_FFFF;
        for (int k = 1; k < w; k++) begin
            check("R7", "start during wait", xfer_start, 0);
            check("R10", "strobe during wait", {ctl_load, wr_en, ready}, 0);
            @(negedge clk);
        end
        for (int b = 0; b < nb; b++) begin
            blen = (sub && rd) ? ((b < 2) ? 2 : 4) : int'(len) + 1;
            for (int j = 0; j < blen; j++) begin
                if (b == 0 && j == 0) begin
                    check("R12", "xfer_addr", xfer_addr, addr);
                    check("R4",  "xfer_dev", xfer_dev, dev);
                    check("R4",  "xfer_read", xfer_read, rd);
                    check("R9",  "xfer_nonseq", xfer_nonseq, exp_ns);
                end
                check((sub && rd) ? "R8" : ((blen == 1) ? "R6" : "R5"), "start marker",
                      xfer_start, (j == 0));
                check((sub && rd) ? "R8" : ((blen == 1) ? "R6" : "R5"), "last marker",
                      xfer_last, (j == blen - 1));
                check("R10", "busy strobes", {ctl_load, wr_en, ready}, 0);
                @(negedge clk);
            end
        end
        cmd_code = 2'd0;
        check("R11", "ready after final beat", ready, 1);
        check("R11", "no marker after final beat", {xfer_start, xfer_last}, 0);
        check("R12", "device held", xfer_dev, dev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "ready in reset", ready, 1);
        check("R1", "outputs in reset", {wr_en, ctl_load, xfer_start, xfer_last}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", ready, 1);

        // table of DMA descriptors
        for (int i = 0; i < NVEC; i++) begin
            run_dma(VEC[i], 32'h1000_0000 + 32'(i) * 32'h40,
                    (i % 3 == 0) ? 2'd0 : ((i % 3 == 1) ? 2'd2 : 2'd1));
        end

        // R2 register writes
        for (int n = 0; n < 2; n++) begin
            cmd_code = 2'd1;
            cmd_data = 32'hA000_0010 + 32'(n);
            @(negedge clk);
            check("R2", "ready after write accept", ready, 0);
            cmd_code = 2'd0;
            cmd_data = 32'h5555_0000 ^ 32'(n * 7);
            @(negedge clk);
            check("R2", "wr_en", wr_en, 1);
            check("R2", "wr_addr", wr_addr, 32'hA000_0010 + 32'(n));
            check("R2", "wr_data", wr_data, 32'h5555_0000 ^ 32'(n * 7));
            check("R2", "ready during write", ready, 0);
            @(negedge clk);
            check("R2", "wr_en single", wr_en, 0);
            check("R2", "ready after write", ready, 1);
        end

        // R3 refresh
        cmd_code = 2'd2;
        cmd_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cmd_code = 2'd0;
        check("R3", "ctl_load", ctl_load, 1);
        check("R3", "ready during refresh", ready, 0);
        @(negedge clk);
        check("R3", "ctl_load single", ctl_load, 0);
        check("R3", "ready after refresh", ready, 1);

        // R10 idle code has no effect
        cmd_data = 32'hFFFF_FFFF;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R10", "idle keeps ready", ready, 1);
            check("R10", "idle no strobes", {wr_en, ctl_load, xfer_start, xfer_last}, 0);
        end

        // refresh right after a transfer
        run_dma(VEC[1], 32'h2000_0000, 2'd2);
        cmd_code = 2'd2;
        @(negedge clk);
        cmd_code = 2'd0;
        check("R3", "refresh after transfer", ctl_load, 1);
        @(negedge clk);
        check("R3", "ready after refresh", ready, 1);

        finish_run();
    end

endmodule